// File: doc/BRIEF.md
# Block Memory Micro-Op Sequencer

This block turns one decoded multi-register memory instruction into a run of single memory micro-operations. The instruction has one of two shapes. A block transfer moves eight consecutive registers through eight doubleword accesses. A twin load fills an even/odd register pair through two doubleword accesses. The decoder hands over the first source operand, a second operand and the operation flags in a single request. The second operand is either a register value or a 13-bit signed immediate. The sequencer accepts the request only while it is idle. It then presents one micro-op per cycle to the memory pipeline under a valid/ready handshake.

Each micro-op carries the following fields:
- an effective address that steps by 8 bytes per micro-op;
- the register index it moves;
- whether it is a store;
- a fault code;
- a last-op flag, or else a delayed-commit flag.

Faults are judged once, on the first micro-op. A faulting instruction ends after that one micro-op.

Top module: `blkmem_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to idle. After that edge `uop_valid` is 0 and `req_ready` is 1.
- R2: An accepted block request (`req_twin`=0) with no fault yields exactly 8 micro-ops with indices 0 to 7. After the last one is taken, `uop_valid` is 0.
- R3: An accepted twin request (`req_twin`=1) with no fault yields exactly 2 micro-ops.
- R4: In register form (`req_use_imm`=0), micro-op n has address `req_rs1 + req_rs2 + 8*n`, modulo 2^64.
- R5: In immediate form (`req_use_imm`=1), micro-op n has address `req_rs1 + sext(req_imm) + 8*n`. Bit 12 of the immediate is the sign bit.
- R6: The final micro-op has `uop_last`=1 and `uop_delay`=0. Every earlier micro-op has `uop_last`=0 and `uop_delay`=1.
- R7: In block mode, micro-op n names register `req_reg + n`, modulo 32.
- R8: In twin mode, micro-op 0 names the even register of the pair holding `req_reg`, and micro-op 1 names the odd register of that pair.
- R9: The fault code is 0 for none, 1 for a privilege fault and 2 for an alignment fault. Only micro-op 0 may carry a nonzero code. When both checks fail, code 2 is reported.
- R10: A faulting request emits only micro-op 0, with `uop_last`=1, and then returns to idle.
- R11: While `uop_valid`=1 and `uop_ready`=0, every micro-op output holds its value.
- R12: `req_ready` is 1 only while no micro-op is pending. A request presented during a sequence is ignored.
- R13: The alignment fault fires when the base address (the address of micro-op 0) has any bit set below bit 6 in block mode, or below bit 4 in twin mode. The privilege fault fires when `req_priv`=0 and `req_space` is below 8'h80.
- R14: Twin requests are always loads. `req_store` is ignored in twin mode and `uop_store` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_rs1 | input | 64 | First address operand |
| req_rs2 | input | 64 | Second address operand (register form) |
| req_imm | input | 13 | Signed immediate (immediate form) |
| req_use_imm | input | 1 | 1 selects the immediate form |
| req_store | input | 1 | 1 for store, 0 for load |
| req_twin | input | 1 | 1 for twin load, 0 for block transfer |
| req_reg | input | 5 | First data register number |
| req_priv | input | 1 | Requester runs privileged |
| req_space | input | 8 | Address-space identifier |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_addr | output | 64 | Effective address |
| uop_reg | output | 5 | Register index moved |
| uop_store | output | 1 | Micro-op is a store |
| uop_last | output | 1 | Final micro-op of the instruction |
| uop_delay | output | 1 | Commit deferred to the final micro-op |
| uop_fault | output | 2 | Fault code |

## Verification
The assertions assume a few things about the environment:
- `uop_ready` is a plain level that the consumer may drop at any time, including in the middle of a sequence.
- Requests may arrive while the sequencer is busy.
- Address arithmetic may wrap.

The stimulus exercises these conditions inside those limits. It drives inputs only at falling edges and stalls the consumer partway through a block run. While the run is stalled, it holds a different request on the input with `req_valid` high. It includes a negative immediate and a register number that wraps past 31. It also applies reset in the middle of a sequence.

// File: rtl/blkmem_pkg.sv
// Shared types for the block memory micro-op sequencer.
package blkmem_pkg;
    // Fault code carried on a micro-op; the encoding is visible at the port.
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_PRIV  = 2'd1,
        FLT_ALIGN = 2'd2
    } fault_e;
endpackage

// File: rtl/blkmem_addr_gen.sv
// Address generation for the sequencer.
// Forms the base effective address of a request from the first operand plus
// either the second operand or the sign-extended immediate. It also steps a
// stored base by STEP_BYTES per micro-op index.
// Assumes: IMM_W < ADDR_W; arithmetic wraps modulo 2^ADDR_W.
module blkmem_addr_gen #(
    parameter int ADDR_W     = 64,
    parameter int IMM_W      = 13,
    parameter int IDX_W      = 3,
    parameter int STEP_BYTES = 8
) (
    input  logic [ADDR_W-1:0] rs1,
    input  logic [ADDR_W-1:0] rs2,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base_ea,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int EXT_W = ADDR_W - IMM_W;
    localparam bit STEP_POW2 = (STEP_BYTES & (STEP_BYTES - 1)) == 0;

    logic [ADDR_W-1:0] operand2;
    logic [ADDR_W-1:0] offset;

    // Select and sign-extend the second operand, then form the base.
    always_comb begin
        operand2 = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : rs2;
        base_ea  = rs1 + operand2;
    end

    // Byte offset of micro-op idx: a shift for power-of-two steps, else a multiply.
    generate
        if (STEP_POW2) begin : g_shift
            localparam int SH = $clog2(STEP_BYTES);
            assign offset = ADDR_W'(idx) << SH;
        end else begin : g_mult
            assign offset = ADDR_W'(idx) * ADDR_W'(STEP_BYTES);
        end
    endgenerate

    // Address of the current micro-op.
    assign op_addr = base_q + offset;
endmodule

// File: rtl/blkmem_fault_chk.sv
// Fault check for the first micro-op of a request.
// Two checks run. The first is an alternate address-space privilege
// violation. The second is base alignment: the whole transfer span in block
// mode, or the pair span in twin mode. Alignment has the higher priority.
// Assumes: the spans are powers of two.
module blkmem_fault_chk
    import blkmem_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int SPACE_W     = 8,
    parameter int BLOCK_OPS   = 8,
    parameter int TWIN_OPS    = 2,
    parameter int STEP_BYTES  = 8,
    parameter int PRIV_LIMIT  = 8'h80
) (
    input  logic [ADDR_W-1:0]  base_ea,
    input  logic               twin,
    input  logic               priv,
    input  logic [SPACE_W-1:0] space,
    output fault_e             fault
);
    localparam int BLK_LSB = $clog2(BLOCK_OPS * STEP_BYTES);
    localparam int TWN_LSB = $clog2(TWIN_OPS * STEP_BYTES);

    logic misaligned;
    logic priv_bad;

    // Alignment and privilege tests on the base address and the requester.
    always_comb begin
        misaligned = twin ? (|base_ea[TWN_LSB-1:0]) : (|base_ea[BLK_LSB-1:0]);
        priv_bad   = !priv && (32'(space) < PRIV_LIMIT);
    end

    // Priority: alignment overrides privilege.
    always_comb begin
        if (misaligned)    fault = FLT_ALIGN;
        else if (priv_bad) fault = FLT_PRIV;
        else               fault = FLT_NONE;
    end
endmodule

// File: rtl/blkmem_seq_ctrl.sv
// Sequence control: an idle/busy state and the micro-op index counter.
// A start pulse loads index 0. Every taken micro-op advances the index.
// Taking a micro-op flagged final returns the controller to idle.
// Assumes: start is asserted only while idle.
module blkmem_seq_ctrl #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             take,
    input  logic             is_final,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    // State and index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && take) begin
            if (is_final) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blkmem_seq.sv
// Block memory micro-op sequencer, top level.
// Accepts one block or twin request while idle. It latches the base
// address, the fault verdict and the operand fields, then issues one
// micro-op per cycle under valid/ready. A fault cuts the run to a single
// micro-op. Every micro-op but the final one asks for delayed commit.
// Assumes: the consumer may hold uop_ready low at any time.
module blkmem_seq
    import blkmem_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int IMM_W      = 13,
    parameter int REG_W      = 5,
    parameter int SPACE_W    = 8,
    parameter int BLOCK_OPS  = 8,
    parameter int TWIN_OPS   = 2,
    parameter int STEP_BYTES = 8,
    parameter int PRIV_LIMIT = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_rs1,
    input  logic [ADDR_W-1:0]  req_rs2,
    input  logic [IMM_W-1:0]   req_imm,
    input  logic               req_use_imm,
    input  logic               req_store,
    input  logic               req_twin,
    input  logic [REG_W-1:0]   req_reg,
    input  logic               req_priv,
    input  logic [SPACE_W-1:0] req_space,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [ADDR_W-1:0]  uop_addr,
    output logic [REG_W-1:0]   uop_reg,
    output logic               uop_store,
    output logic               uop_last,
    output logic               uop_delay,
    output logic [1:0]         uop_fault
);
    localparam int IDX_W = $clog2(BLOCK_OPS);
    localparam logic [IDX_W-1:0] BLK_LAST = IDX_W'(BLOCK_OPS - 1);
    localparam logic [IDX_W-1:0] TWN_LAST = IDX_W'(TWIN_OPS - 1);

    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic              start;
    logic              take;
    logic              is_final;
    logic              first_faults;
    logic [ADDR_W-1:0] base_ea;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] op_addr;
    fault_e            fault_new;
    fault_e            fault_q;
    logic              twin_q;
    logic              store_q;
    logic [REG_W-1:0]  reg_q;

    assign req_ready = !busy;
    assign start     = req_valid && !busy;
    assign take      = busy && uop_ready;

    blkmem_addr_gen #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .STEP_BYTES(STEP_BYTES)
    ) u_addr (
        .rs1(req_rs1), .rs2(req_rs2), .imm(req_imm), .use_imm(req_use_imm),
        .base_q(base_q), .idx(idx), .base_ea(base_ea), .op_addr(op_addr)
    );

    blkmem_fault_chk #(
        .ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .BLOCK_OPS(BLOCK_OPS),
        .TWIN_OPS(TWIN_OPS), .STEP_BYTES(STEP_BYTES), .PRIV_LIMIT(PRIV_LIMIT)
    ) u_fault (
        .base_ea(base_ea), .twin(req_twin), .priv(req_priv),
        .space(req_space), .fault(fault_new)
    );

    blkmem_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .take(take),
        .is_final(is_final), .busy(busy), .idx(idx)
    );

    // Capture the request fields when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            fault_q <= FLT_NONE;
            twin_q  <= 1'b0;
            store_q <= 1'b0;
            reg_q   <= '0;
        end else if (start) begin
            base_q  <= base_ea;
            fault_q <= fault_new;
            twin_q  <= req_twin;
            store_q <= req_store && !req_twin;
            reg_q   <= req_reg;
        end
    end

    // Final-op decision: a fault on the first op, or the mode's last index.
    always_comb begin
        first_faults = (idx == '0) && (fault_q != FLT_NONE);
        is_final     = first_faults || (idx == (twin_q ? TWN_LAST : BLK_LAST));
    end

    // Micro-op outputs.
    always_comb begin
        uop_valid = busy;
        uop_addr  = op_addr;
        uop_reg   = twin_q ? {reg_q[REG_W-1:1], idx[0]} : reg_q + REG_W'(idx);
        uop_store = store_q;
        uop_last  = busy && is_final;
        uop_delay = busy && !is_final;
        uop_fault = (idx == '0) ? fault_q : FLT_NONE;
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_addr) &&
        $stable(uop_reg) && $stable(uop_last) && $stable(uop_fault));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && !uop_last |=>
        uop_valid && (uop_addr == $past(uop_addr) + ADDR_W'(STEP_BYTES)));

    // R9
    fault_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && !uop_last |=> uop_fault == 2'd0);

    // R10
    fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && (uop_fault != 2'd0) |-> uop_last && !uop_delay);

    // R2
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && uop_last |=> !uop_valid && req_ready);

    // R12
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !uop_valid);
endmodule

// File: tb/blkmem_seq_bench.sv
module blkmem_seq_bench;
    typedef struct packed {
        logic [63:0] rs1;
        logic [63:0] rs2;
        logic [12:0] imm;
        logic        use_imm;
        logic        store;
        logic        twin;
        logic [4:0]  rg;
        logic        priv;
        logic [7:0]  space;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{64'h1000, 64'h40, 13'h0,    1'b0, 1'b0, 1'b0, 5'd8,  1'b1, 8'h80},
        '{64'h2080, 64'h0,  13'h1FC0, 1'b1, 1'b1, 1'b0, 5'd28, 1'b0, 8'h82},
        '{64'h3000, 64'h10, 13'h0,    1'b0, 1'b1, 1'b1, 5'd7,  1'b0, 8'h80},
        '{64'h5000, 64'h0,  13'h0FF0, 1'b1, 1'b0, 1'b1, 5'd4,  1'b1, 8'h90},
        '{64'h1000, 64'h0,  13'h0,    1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 8'h10},
        '{64'h1008, 64'h0,  13'h0,    1'b0, 1'b1, 1'b0, 5'd0,  1'b1, 8'h80},
        '{64'h4004, 64'h0,  13'h0,    1'b0, 1'b0, 1'b1, 5'd2,  1'b0, 8'h04},
        '{64'h6010, 64'h0,  13'h0,    1'b0, 1'b0, 1'b1, 5'd10, 1'b1, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_rs1 = '0, req_rs2 = '0;
    logic [12:0] req_imm = '0;
    logic        req_use_imm = 1'b0, req_store = 1'b0, req_twin = 1'b0;
    logic [4:0]  req_reg = '0;
    logic        req_priv = 1'b0;
    logic [7:0]  req_space = '0;
    logic        uop_valid, uop_ready = 1'b1;
    logic [63:0] uop_addr;
    logic [4:0]  uop_reg;
    logic        uop_store, uop_last, uop_delay;
    logic [1:0]  uop_fault;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    blkmem_seq u_blkmem_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rs1(req_rs1), .req_rs2(req_rs2), .req_imm(req_imm),
        .req_use_imm(req_use_imm), .req_store(req_store), .req_twin(req_twin),
        .req_reg(req_reg), .req_priv(req_priv), .req_space(req_space),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_addr(uop_addr),
        .uop_reg(uop_reg), .uop_store(uop_store), .uop_last(uop_last),
        .uop_delay(uop_delay), .uop_fault(uop_fault)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model_fault(input vec_t v);
        logic [63:0] b;
        b = v.rs1 + (v.use_imm ? {{51{v.imm[12]}}, v.imm} : v.rs2);
        if (v.twin ? (b[3:0] != 0) : (b[5:0] != 0)) return 2'd2;
        if (!v.priv && v.space < 8'h80) return 2'd1;
        return 2'd0;
    endfunction

    // Issue one request and check each micro-op; optionally stall at op stall_at.
    task automatic run_seq(input vec_t v, input int stall_at);
        logic [63:0] base;
        logic [1:0]  f;
        int          nops;
        base = v.rs1 + (v.use_imm ? {{51{v.imm[12]}}, v.imm} : v.rs2);
        f    = model_fault(v);
        nops = (f != 0) ? 1 : (v.twin ? 2 : 8);
        @(negedge clk);
        chk("R12 ready idle", 64'(req_ready), 64'd1);
        req_rs1 = v.rs1; req_rs2 = v.rs2; req_imm = v.imm;
        req_use_imm = v.use_imm; req_store = v.store; req_twin = v.twin;
        req_reg = v.rg; req_priv = v.priv; req_space = v.space;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < nops; n++) begin
            if (n == stall_at) begin
                uop_ready = 1'b0;
                req_rs1 = 64'hDEAD_0000; req_reg = 5'd1; req_valid = 1'b1;
                for (int s = 0; s < 3; s++) @(negedge clk);
                req_valid = 1'b0;
                uop_ready = 1'b1;
            end
            chk("R2/R3 valid", 64'(uop_valid), 64'd1);
            chk(v.use_imm ? "R5 addr" : "R4 addr", uop_addr, base + 64'(8 * n));
            chk(v.twin ? "R8 reg" : "R7 reg", 64'(uop_reg),
                v.twin ? 64'({v.rg[4:1], n[0]}) : 64'(5'(v.rg + 5'(n))));
            chk("R6 last", 64'(uop_last), 64'(n == nops - 1));
            chk("R6 delay", 64'(uop_delay), 64'(n != nops - 1));
            chk("R9 R13 fault", 64'(uop_fault), (n == 0) ? 64'(f) : 64'd0);
            chk("R14 store", 64'(uop_store), 64'(v.store && !v.twin));
            @(negedge clk);
        end
        chk("R2 R10 idle after", 64'(uop_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 64'(uop_valid), 64'd0);
        chk("R1 ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_seq(VECS[i], -1);
        // R11, R12: stall mid-block with a competing request
        run_seq(VECS[0], 2);
        // R1: reset in the middle of a sequence
        @(negedge clk);
        req_rs1 = 64'h1000; req_rs2 = 0; req_twin = 0; req_priv = 1; req_space = 8'h80;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid valid", 64'(uop_valid), 64'd0);
        chk("R1 mid ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule